// File: doc/BRIEF.md
# Multi-mode 24-bit up/down counter

This block is a single-axis synchronous up/down counter with six 4-bit digit positions, 24 bits in all. A separate decoder supplies a count request and a direction on every clock. A preset word does two jobs. It is the value loaded into the counter on request, and it is the compare value and the programmable boundary for the bounded modes.

A mode input selects plain binary or six-digit BCD arithmetic. It also selects one of four boundary behaviours:
- **Free wrap:** the counter passes from one end of its range to the other.
- **Clamp between zero and the preset:** the counter stops at either limit.
- **One-shot:** the counter stops for good after its first overflow or underflow.
- **Bidirectional divide-by-(preset+1):** the counter cycles through preset+1 states in either direction.

The block registers one-cycle carry, borrow and match pulses together with the counter update. It keeps a status byte that holds toggle copies of those pulses, a sign bit and the last direction requested. Synchronous inputs load the preset, clear the counter and clear the event flags.

Top module: `updn_counter24`

## Requirements
- R1: After reset the count is 0, the carry, borrow and match pulses are low and the status byte is 0x00.
- R2: With `mode[2:1]`=00 and `mode[0]`=0, an up step at 0xFFFFFF gives 0 and a carry pulse, and a down step at 0 gives 0xFFFFFF and a borrow pulse. Every other step changes the count by one.
- R3: With `mode[0]`=1, each nibble counts 0 to 9 in decimal. An up step at 999999 gives 000000 with a carry, and a down step at 000000 gives 999999 with a borrow. The preset is read as BCD in this mode.
- R4: With `mode[2:1]`=01, an up request while count equals the preset leaves the count unchanged, and so does a down request at 0. Neither case makes a pulse. The count moves again as soon as the direction is reversed.
- R5: With `mode[2:1]`=10, the step that overflows or underflows wraps the count and pulses carry or borrow. After that step, count requests are ignored until a preset load or a counter clear.
- R6: With `mode[2:1]`=11, an up step at count equal to the preset gives 0 with a carry, and a down step at 0 gives the preset with a borrow. The period is preset+1 steps in both directions.
- R7: `match_p` pulses for one cycle after a count step that leaves the counter equal to the preset. A held (clamped) request does not pulse it.
- R8: Status bit 0 flips on every borrow, bit 1 on every carry and bit 2 on every match. Bit 3 is set by a borrow and cleared by a carry. Bit 5 holds the direction of the last cycle with `cnt_en` high (1 = up). Bits 4, 6 and 7 read 0.
- R9: `load_pre` takes priority over `clr_cnt`, and both take priority over a count request in the same cycle. Either one re-enables counting that one-shot mode has stopped.
- R10: `clr_flags` clears status bits 0 to 3 and wins over any event in the same cycle. Bit 5 is left unchanged.
- R11: Carry, borrow and match are active-high pulses registered on the same edge as the count they belong to. Carry and borrow never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count request for this cycle |
| cnt_up | input | 1 | Direction of the request, 1 = up |
| preset | input | 24 | Load value, compare value and boundary |
| mode | input | 4 | [0] BCD, [2:1] boundary behaviour, [3] reserved |
| load_pre | input | 1 | Load the preset into the counter |
| clr_cnt | input | 1 | Clear the counter to zero |
| clr_flags | input | 1 | Clear the toggle bits and the sign bit |
| count | output | 24 | Counter value |
| carry_p | output | 1 | Overflow pulse |
| borrow_p | output | 1 | Underflow pulse |
| match_p | output | 1 | Compare pulse |
| status | output | 8 | Status byte |

## Verification
The bench drives the counter onto every boundary of every mode.

| Boundary | What a wrong design shows |
|---|---|
| Binary wrap at 0xFFFFFF and BCD wrap at 999999 | A BCD counter that leaks into hex digits shows 0x99999A. |
| Clamp limits | A clamp that lets the count slip past the preset, or emits a spurious pulse while frozen, shows a count or pulse mismatch. |
| Stop in one-shot mode | A one-shot counter that keeps counting after its borrow, or stays dead after a load, shows a count mismatch. |
| Divide-by-(preset+1) reload | A divider that reloads all-ones instead of the preset when counting down shows a count mismatch. |

A behavioural model computes every expected value, and the bench compares it on every clock under both directed runs and long mixed runs. The mixed runs cover every mode combination, so collisions of load, clear, count and flag-clear requests in one cycle expose a wrong priority order at once.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    BND_WRAP    = 2'b00,
    BND_CLAMP   = 2'b01,
    BND_ONESHOT = 2'b10,
    BND_MODN    = 2'b11
  } bound_e;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic match;
  } evt_t;

endpackage

// File: rtl/updn_stepper.sv
module updn_stepper #(
  parameter int DIGITS = 6,
  localparam int CW = 4 * DIGITS
) (
  input  logic [CW-1:0] val,
  input  logic          bcd,
  output logic [CW-1:0] val_inc,
  output logic [CW-1:0] val_dec,
  output logic          at_max,
  output logic          at_zero
);

  logic [DIGITS:0] nine_below;
  logic [DIGITS:0] zero_below;
  logic [CW-1:0]   bcd_inc;
  logic [CW-1:0]   bcd_dec;

  assign nine_below[0] = 1'b1;
  assign zero_below[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    assign dig = val[4*g +: 4];
    assign nine_below[g+1] = nine_below[g] & (dig == 4'd9);
    assign zero_below[g+1] = zero_below[g] & (dig == 4'd0);
    assign bcd_inc[4*g +: 4] = nine_below[g] ? ((dig == 4'd9) ? 4'd0 : dig + 4'd1) : dig;
    assign bcd_dec[4*g +: 4] = zero_below[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
  end

  always_comb begin
    if (bcd) begin
      val_inc = bcd_inc;
      val_dec = bcd_dec;
      at_max  = nine_below[DIGITS];
    end else begin
      val_inc = val + 1'b1;
      val_dec = val - 1'b1;
      at_max  = &val;
    end
    at_zero = zero_below[DIGITS];
  end

endmodule

// File: rtl/updn_bound.sv
module updn_bound
  import updn_pkg::*;
#(
  parameter int DIGITS = 6,
  localparam int CW = 4 * DIGITS
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] preset,
  input  logic          up,
  input  bound_e        bnd,
  input  logic [CW-1:0] val_inc,
  input  logic [CW-1:0] val_dec,
  input  logic          at_max,
  input  logic          at_zero,
  output logic [CW-1:0] nxt,
  output logic          ovf,
  output logic          unf,
  output logic          hold,
  output logic          stop
);

  logic at_pre;
  assign at_pre = (cur == preset);

  always_comb begin
    nxt  = cur;
    ovf  = 1'b0;
    unf  = 1'b0;
    hold = 1'b0;
    if (up) begin
      if (bnd == BND_CLAMP && at_pre) begin
        hold = 1'b1;
      end else if ((bnd == BND_MODN && at_pre) || at_max) begin
        nxt = '0;
        ovf = 1'b1;
      end else begin
        nxt = val_inc;
      end
    end else begin
      if (at_zero) begin
        if (bnd == BND_CLAMP) begin
          hold = 1'b1;
        end else if (bnd == BND_MODN) begin
          nxt = preset;
          unf = 1'b1;
        end else begin
          nxt = val_dec;
          unf = 1'b1;
        end
      end else begin
        nxt = val_dec;
      end
    end
    stop = (bnd == BND_ONESHOT) && (ovf || unf);
  end

endmodule

// File: rtl/updn_flags.sv
module updn_flags
  import updn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evt_t       ev,
  input  logic       clr,
  input  logic       dir_we,
  input  logic       dir_in,
  output logic [7:0] status
);

  logic bt_q, ct_q, cpt_q, sign_q, dir_q;
  logic bt_d, ct_d, cpt_d, sign_d, dir_d;

  always_comb begin
    bt_d   = bt_q;
    ct_d   = ct_q;
    cpt_d  = cpt_q;
    sign_d = sign_q;
    if (clr) begin
      bt_d   = 1'b0;
      ct_d   = 1'b0;
      cpt_d  = 1'b0;
      sign_d = 1'b0;
    end else begin
      if (ev.borrow) begin
        bt_d   = ~bt_q;
        sign_d = 1'b1;
      end
      if (ev.carry) begin
        ct_d   = ~ct_q;
        sign_d = 1'b0;
      end
      if (ev.match) cpt_d = ~cpt_q;
    end
    dir_d = dir_we ? dir_in : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bt_q   <= 1'b0;
      ct_q   <= 1'b0;
      cpt_q  <= 1'b0;
      sign_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      bt_q   <= bt_d;
      ct_q   <= ct_d;
      cpt_q  <= cpt_d;
      sign_q <= sign_d;
      dir_q  <= dir_d;
    end
  end

  assign status = {1'b0, 1'b0, dir_q, 1'b0, sign_q, cpt_q, ct_q, bt_q};

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> status[3:0] == 4'h0);

  // R8
  carry_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.carry && !clr) |=> status[1] != $past(status[1]));

  // R8
  borrow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.borrow && !ev.carry && !clr) |=> status[3]);

endmodule

// File: rtl/updn_counter24.sv
module updn_counter24
  import updn_pkg::*;
#(
  parameter int DIGITS = 6,
  localparam int CW = 4 * DIGITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_up,
  input  logic [CW-1:0] preset,
  input  logic [3:0]    mode,
  input  logic          load_pre,
  input  logic          clr_cnt,
  input  logic          clr_flags,
  output logic [CW-1:0] count,
  output logic          carry_p,
  output logic          borrow_p,
  output logic          match_p,
  output logic [7:0]    status
);

  logic rst_meta_n, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  logic mode_unused;
  assign mode_unused = mode[3];

  bound_e bnd;
  assign bnd = bound_e'(mode[2:1]);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  evt_t          ev, ev_q;

  logic [CW-1:0] val_inc, val_dec, nxt;
  logic          at_max, at_zero, ovf, unf, hold, stop;
  logic          do_step;

  updn_stepper #(.DIGITS(DIGITS)) stepper_i (
    .val     (cnt_q),
    .bcd     (mode[0]),
    .val_inc (val_inc),
    .val_dec (val_dec),
    .at_max  (at_max),
    .at_zero (at_zero)
  );

  updn_bound #(.DIGITS(DIGITS)) bound_i (
    .cur     (cnt_q),
    .preset  (preset),
    .up      (cnt_up),
    .bnd     (bnd),
    .val_inc (val_inc),
    .val_dec (val_dec),
    .at_max  (at_max),
    .at_zero (at_zero),
    .nxt     (nxt),
    .ovf     (ovf),
    .unf     (unf),
    .hold    (hold),
    .stop    (stop)
  );

  assign do_step = cnt_en && run_q && !load_pre && !clr_cnt;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_pre) begin
      cnt_d = preset;
      run_d = 1'b1;
    end else if (clr_cnt) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (do_step) begin
      if (!hold) cnt_d = nxt;
      if (stop) run_d = 1'b0;
    end
    ev.carry  = do_step && ovf;
    ev.borrow = do_step && unf;
    ev.match  = do_step && !hold && (nxt == preset);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      ev_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      ev_q  <= ev;
    end
  end

  updn_flags flags_i (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .ev     (ev),
    .clr    (clr_flags),
    .dir_we (cnt_en),
    .dir_in (cnt_up),
    .status (status)
  );

  assign count    = cnt_q;
  assign carry_p  = ev_q.carry;
  assign borrow_p = ev_q.borrow;
  assign match_p  = ev_q.match;

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    load_pre |=> count == $past(preset));

  // R9
  clear_next_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clr_cnt && !load_pre) |=> count == '0);

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(carry_p && borrow_p));

  // R4
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode[2:1] == 2'b01 && cnt_en && cnt_up && !load_pre && !clr_cnt && count == preset)
      |=> ($stable(count) && !carry_p && !match_p));

  // R11
  carry_edge_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (carry_p && mode[2:1] == 2'b00 && $stable(mode)) |-> count == '0);

endmodule

// File: tb/updn_counter24_tb_top.sv
module updn_counter24_tb_top;

  localparam int CW = 24;

  logic          clk;
  logic          rst_n;
  logic          cnt_en, cnt_up, load_pre, clr_cnt, clr_flags;
  logic [CW-1:0] preset;
  logic [3:0]    mode;
  logic [CW-1:0] count;
  logic          carry_p, borrow_p, match_p;
  logic [7:0]    status;

  updn_counter24 dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .preset    (preset),
    .mode      (mode),
    .load_pre  (load_pre),
    .clr_cnt   (clr_cnt),
    .clr_flags (clr_flags),
    .count     (count),
    .carry_p   (carry_p),
    .borrow_p  (borrow_p),
    .match_p   (match_p),
    .status    (status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  int  m_val, pv;
  bit  m_run, bt, ct, cpt, sg, dr;
  bit  ec, eb, em;

  function automatic logic [CW-1:0] to_bcd(input int v);
    logic [CW-1:0] r;
    int t;
    r = '0;
    t = v;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] enc(input int v);
    return mode[0] ? to_bcd(v) : CW'(v);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count", int'(count), int'(enc(m_val)));
    chk("R11", "carry_p", int'(carry_p), int'(ec));
    chk("R11", "borrow_p", int'(borrow_p), int'(eb));
    chk("R7", "match_p", int'(match_p), int'(em));
    chk(clr_flags ? "R10" : "R8", "status", int'(status),
        int'({2'b00, dr, 1'b0, sg, cpt, ct, bt}));
  endtask

  task automatic set_preset(input int v);
    pv = v;
    preset = enc(v);
  endtask

  task automatic cyc(input bit en, input bit up, input bit ld, input bit cl,
                     input bit cf, input string tag);
    int mx, bnd;
    bit moved;
    cnt_en = en; cnt_up = up; load_pre = ld; clr_cnt = cl; clr_flags = cf;
    @(posedge clk);
    #1;
    mx  = mode[0] ? 999999 : 24'hFFFFFF;
    bnd = int'(mode[2:1]);
    ec = 0; eb = 0; em = 0;
    if (en) dr = up;
    if (ld) begin
      m_val = pv; m_run = 1;
    end else if (cl) begin
      m_val = 0; m_run = 1;
    end else if (en && m_run) begin
      moved = 1;
      if (up) begin
        if (bnd == 1 && m_val == pv) moved = 0;
        else if ((bnd == 3 && m_val == pv) || m_val == mx) begin m_val = 0; ec = 1; end
        else m_val = m_val + 1;
      end else begin
        if (m_val == 0) begin
          if (bnd == 1) moved = 0;
          else if (bnd == 3) begin m_val = pv; eb = 1; end
          else begin m_val = mx; eb = 1; end
        end else m_val = m_val - 1;
      end
      if (moved && m_val == pv) em = 1;
      if (bnd == 2 && (ec || eb)) m_run = 0;
    end
    if (cf) begin
      bt = 0; ct = 0; cpt = 0; sg = 0;
    end else begin
      if (eb) begin bt = ~bt; sg = 1; end
      if (ec) begin ct = ~ct; sg = 0; end
      if (em) cpt = ~cpt;
    end
    compare_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit dir;
    rst_n = 0; cnt_en = 0; cnt_up = 0; load_pre = 0; clr_cnt = 0; clr_flags = 0;
    mode = 4'b0000; preset = '0; pv = 0;
    m_val = 0; m_run = 1; bt = 0; ct = 0; cpt = 0; sg = 0; dr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    compare_all("R1");

    // R2 binary wrap both ways
    mode = 4'b0000; set_preset(24'hFFFFFE);
    cyc(0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R2");

    // R3 BCD wrap both ways
    mode = 4'b0001; set_preset(999998);
    cyc(0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, "R3");
    set_preset(1009); cyc(0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 0, "R3");

    // R4 clamp at preset and zero
    mode = 4'b0010; set_preset(5);
    cyc(0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R4");
    cyc(1, 1, 0, 0, 0, "R4");

    // R5 one-shot stop and re-enable
    mode = 4'b0100; set_preset(24'hFFFFFD);
    cyc(0, 0, 1, 0, 0, "R9");
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, "R5");
    cyc(1, 1, 1, 0, 0, "R9");
    cyc(0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 1, 0, "R9");
    cyc(1, 0, 0, 0, 0, "R5");

    // R6 divide-by-(preset+1) both directions
    mode = 4'b0110; set_preset(3);
    cyc(0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 9; i++) cyc(1, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 9; i++) cyc(1, 0, 0, 0, 0, "R6");
    mode = 4'b0111; set_preset(12);
    cyc(0, 0, 0, 1, 0, "R9");
    for (int i = 0; i < 15; i++) cyc(1, 1, 0, 0, 0, "R6");

    // R9 priority: load over clear over count
    mode = 4'b0000; set_preset(77);
    cyc(1, 1, 1, 1, 0, "R9");
    cyc(1, 1, 0, 1, 0, "R9");

    // R10 clear beats a carry in the same cycle
    set_preset(24'hFFFFFF);
    cyc(0, 0, 1, 0, 0, "R9");
    cyc(1, 1, 0, 0, 1, "R10");
    cyc(1, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 0, 1, "R10");

    // mixed runs over all mode combinations
    dir = 1;
    for (int md = 0; md < 8; md++) begin
      mode = 4'(md);
      set_preset(($urandom % 30) + 1);
      cyc(0, 0, 0, 1, 0, "R9");
      for (int k = 0; k < 400; k++) begin
        if ($urandom % 8 == 0) dir = ~dir;
        if ($urandom % 40 == 0) set_preset(($urandom % 30) + 1);
        cyc(($urandom % 10) < 7, dir, ($urandom % 40) == 0, ($urandom % 50) == 0,
            ($urandom % 30) == 0, "R9");
      end
    end

    finish_run();
  end

endmodule